// File: doc/BRIEF.md
# Filtered Performance Event Counter Bank

This block is a small bank of event counters for profiling a processor core. Each counter watches one line of an event input vector. It adds one in every cycle where four things hold: the selected event is high, the current privilege mode is not masked out, the marked-state filter accepts the current value of a software-controlled marked bit, and the counter's line in a global inhibit vector is low. One 64-bit configuration word per counter holds every control for that counter. Software therefore sets up a counter with two plain writes, one to the configuration word and one to the count, and never needs a read-modify-write.

The marked bit lets software tag a class of work, for example rare error-handling routines. It can then profile only that work, only the rest, or both at once. Two or more counters can follow the same event under different marked filters in the same run. Overflow is taken as the count's top bit going from 0 to 1, so the count remains one unsigned number that a single read returns. Each overflow sets a sticky status bit, and that bit can raise an interrupt.

Top module: `perf_counter_bank`

## Requirements
- R1: A counter whose qualifying conditions all hold in a cycle holds its old value plus one after that clock edge. In any other cycle without a write, it keeps its value.
- R2: Configuration bits 31:0 select the event. Value 0 selects no event. A value s from 1 to 8 selects event_i[s-1]. Any larger value selects no event.
- R3: Configuration bits 60:57 form a mode-inhibit mask, and bit 57+m blocks counting while priv_mode_i equals m. The mode encoding is 0 user, 1 supervisor, 2 reserved, 3 machine.
- R4: Configuration bits 62:61 filter on marked_i. The value 00 counts regardless of marked_i, 01 counts only while marked_i is 1, 10 counts only while marked_i is 0, and 11 never counts.
- R5: While inhibit_i[k] is 1, counter k does not change, whatever its configuration.
- R6: An increment that takes counter k from 0x7FFF_FFFF_FFFF_FFFF to 0x8000_0000_0000_0000 sets status bit k. An increment that wraps all-ones to zero sets no status bit.
- R7: Status bits are sticky. Writing status address 8 clears each bit that has a 1 in wr_data_i[3:0] and leaves the others unchanged. If an overflow and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: irq_o is 1 exactly when some status bit k is set and bit 63 of configuration k is 1.
- R9: A write to a counter in the same cycle as a qualified increment loads the written value. Writing any value to a counter, 0x8000_0000_0000_0000 included, never sets a status bit.
- R10: The register map is: addresses 0 to 3 are counters 0 to 3, addresses 4 to 7 are configurations 0 to 3, and address 8 is status in bits 3:0. rd_data_o shows the addressed register in the same cycle. Unmapped addresses read as zero.
- R11: Counters that select the same event with different marked filters count independently, each according to its own filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; clears counts, configurations and status |
| event_i | input | 8 | Event lines, one per countable event |
| priv_mode_i | input | 2 | Current privilege mode (0 user, 1 supervisor, 2 reserved, 3 machine) |
| marked_i | input | 1 | Software-set marked state of the running work |
| inhibit_i | input | 4 | Per-counter global stop |
| wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for read and write |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Addressed register value, combinational |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A long stretch of random cycles drives random event lines, modes, marked values and inhibits against random configurations, including event selectors beyond the last line. This separates faults in the AND of the four qualifiers and in the selector decode from correct counting. Directed cases place counts just below the top-bit boundary and at all-ones. These cases show whether overflow is taken on the top-bit rise and not on wraparound, whether a write beats an increment, and how a clear interacts with a same-cycle overflow. A run with three counters on one event, each under a different marked filter, while marked_i toggles, shows whether the filters are decoded per counter.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int SEL_W = 32;
    typedef enum logic [1:0] {
        MF_ANY       = 2'b00,
        MF_MARKED    = 2'b01,
        MF_UNMARKED  = 2'b10,
        MF_NEVER     = 2'b11
    } mark_filt_e;
endpackage

// File: rtl/pcb_filter.sv
module pcb_filter
    import pcb_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [3:0]         mmask_i,
    input  logic [1:0]         mfilt_i,
    input  logic [NUM_EVT-1:0] event_i,
    input  logic [1:0]         priv_i,
    input  logic               marked_i,
    input  logic               inhibit_i,
    output logic               count_o
);
    logic evt_hit;
    logic mode_ok;
    logic mark_ok;

    always_comb begin
        evt_hit = 1'b0;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (sel_i == SEL_W'(e + 1)) evt_hit = event_i[e];
        end
        mode_ok = !mmask_i[priv_i];
        case (mark_filt_e'(mfilt_i))
            MF_ANY:      mark_ok = 1'b1;
            MF_MARKED:   mark_ok = marked_i;
            MF_UNMARKED: mark_ok = !marked_i;
            default:     mark_ok = 1'b0;
        endcase
        count_o = evt_hit && mode_ok && mark_ok && !inhibit_i;
    end
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
    parameter int XLEN = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            inc_i,
    input  logic            wr_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] cnt_o,
    output logic            ovf_o
);
    typedef struct packed {
        logic [XLEN-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic [XLEN-1:0] plus_one;

    always_comb begin
        st_d     = st_q;
        plus_one = st_q.cnt + XLEN'(1);
        ovf_o    = 1'b0;
        if (wr_i) begin
            st_d.cnt = wdata_i;
        end else if (inc_i) begin
            st_d.cnt = plus_one;
            ovf_o    = !st_q.cnt[XLEN-1] && plus_one[XLEN-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R9: a write loads the written value whatever the increment does
    assert_write_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> cnt_o == $past(wdata_i));

    // R1: without a write the count moves by zero or one
    assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + XLEN'(1)));

    // R6: an overflow flag means the top bit has just risen
    assert_top_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> cnt_o[XLEN-1] && !$past(cnt_o[XLEN-1]));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int XLEN    = 64,
    parameter int NUM_EVT = 8,
    parameter int ADDR_W  = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EVT-1:0] event_i,
    input  logic [1:0]         priv_mode_i,
    input  logic               marked_i,
    input  logic [NUM_CTR-1:0] inhibit_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [XLEN-1:0]    wr_data_i,
    output logic [XLEN-1:0]    rd_data_o,
    output logic               irq_o
);
    localparam int CFG_BASE = NUM_CTR;
    localparam int ST_ADDR  = 2 * NUM_CTR;
    localparam int IE_BIT   = XLEN - 1;
    localparam int MF_HI    = XLEN - 2;
    localparam int MF_LO    = XLEN - 3;
    localparam int MM_HI    = XLEN - 4;
    localparam int MM_LO    = XLEN - 7;

    typedef struct packed {
        logic [NUM_CTR-1:0][XLEN-1:0] cfg;
        logic [NUM_CTR-1:0]           st;
    } bank_state_t;

    bank_state_t regs_d, regs_q;
    logic [NUM_CTR-1:0]           ovf;
    logic [NUM_CTR-1:0]           inc;
    logic [NUM_CTR-1:0]           ctr_wr;
    logic [NUM_CTR-1:0][XLEN-1:0] cnt;
    logic [NUM_CTR-1:0]           st_clr;
    logic [NUM_CTR-1:0]           ie;
    logic                         st_wr;

    assign st_wr = wr_en_i && (reg_addr_i == ADDR_W'(ST_ADDR));

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        assign ctr_wr[k] = wr_en_i && (reg_addr_i == ADDR_W'(k));
        assign ie[k]     = regs_q.cfg[k][IE_BIT];

        pcb_filter #(.NUM_EVT(NUM_EVT)) u_filt (
            .sel_i     (regs_q.cfg[k][SEL_W-1:0]),
            .mmask_i   (regs_q.cfg[k][MM_HI:MM_LO]),
            .mfilt_i   (regs_q.cfg[k][MF_HI:MF_LO]),
            .event_i   (event_i),
            .priv_i    (priv_mode_i),
            .marked_i  (marked_i),
            .inhibit_i (inhibit_i[k]),
            .count_o   (inc[k])
        );

        pcb_counter #(.XLEN(XLEN)) u_ctr (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .inc_i   (inc[k]),
            .wr_i    (ctr_wr[k]),
            .wdata_i (wr_data_i),
            .cnt_o   (cnt[k]),
            .ovf_o   (ovf[k])
        );

        // R7: a set status bit stays set unless software clears it
        assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (regs_q.st[k] && !(st_wr && wr_data_i[k])) |=> regs_q.st[k]);

        // R6: a top-bit rise is always recorded in status
        assert_ovf_recorded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ovf[k] |=> regs_q.st[k]);

        // R5: an inhibited counter without a write holds still
        assert_inhibit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (inhibit_i[k] && !ctr_wr[k]) |=> cnt[k] == $past(cnt[k]));
    end

    always_comb begin
        regs_d = regs_q;
        st_clr = st_wr ? wr_data_i[NUM_CTR-1:0] : '0;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (wr_en_i && (reg_addr_i == ADDR_W'(CFG_BASE + k)))
                regs_d.cfg[k] = wr_data_i;
        end
        regs_d.st = (regs_q.st & ~st_clr) | ovf;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (reg_addr_i == ADDR_W'(k))            rd_data_o = cnt[k];
            if (reg_addr_i == ADDR_W'(CFG_BASE + k)) rd_data_o = regs_q.cfg[k];
        end
        if (reg_addr_i == ADDR_W'(ST_ADDR)) rd_data_o = XLEN'(regs_q.st);
    end

    assign irq_o = |(regs_q.st & ie);
endmodule

// File: tb/perf_counter_bank_tb.sv
`timescale 1ns/1ps
module perf_counter_bank_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  event_i = '0;
    logic [1:0]  priv_mode_i = '0;
    logic        marked_i = 1'b0;
    logic [3:0]  inhibit_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [63:0] wr_data_i = '0;
    logic [63:0] rd_data_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [63:0] m_cnt [4];
    logic [63:0] m_cfg [4];
    logic [3:0]  m_st;

    always #4 clk_i = ~clk_i;

    perf_counter_bank dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .event_i(event_i), .priv_mode_i(priv_mode_i),
        .marked_i(marked_i), .inhibit_i(inhibit_i), .wr_en_i(wr_en_i),
        .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    function automatic logic qualifies(logic [63:0] cfg, logic [7:0] ev, logic [1:0] md,
                                       logic mk, logic inh);
        logic hit;
        logic mark_ok;
        hit = (cfg[31:0] >= 1 && cfg[31:0] <= 8) ? ev[cfg[31:0] - 1] : 1'b0;
        case (cfg[62:61])
            2'b00: mark_ok = 1'b1;
            2'b01: mark_ok = mk;
            2'b10: mark_ok = !mk;
            default: mark_ok = 1'b0;
        endcase
        return hit && !cfg[57 + md] && mark_ok && !inh;
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int k = 0; k < 4; k++) r = r | (m_st[k] & m_cfg[k][63]);
        return r;
    endfunction

    function automatic logic [63:0] exp_reg(int a);
        if (a < 4) return m_cnt[a];
        if (a < 8) return m_cfg[a - 4];
        if (a == 8) return {60'd0, m_st};
        return 64'd0;
    endfunction

    task automatic cycle(logic [7:0] ev, logic [1:0] md, logic mk, logic [3:0] inh,
                         logic we, logic [3:0] addr, logic [63:0] wd);
        logic [3:0] set;
        logic [3:0] clr;
        logic [63:0] nc;
        @(negedge clk_i);
        event_i = ev; priv_mode_i = md; marked_i = mk; inhibit_i = inh;
        wr_en_i = we; reg_addr_i = addr; wr_data_i = wd;
        @(posedge clk_i);
        set = '0;
        for (int k = 0; k < 4; k++) begin
            if (we && addr == 4'(k)) begin
                m_cnt[k] = wd;
            end else if (qualifies(m_cfg[k], ev, md, mk, inh[k])) begin
                nc = m_cnt[k] + 64'd1;
                if (!m_cnt[k][63] && nc[63]) set[k] = 1'b1;
                m_cnt[k] = nc;
            end
        end
        for (int k = 0; k < 4; k++)
            if (we && addr == 4'(k + 4)) m_cfg[k] = wd;
        clr = (we && addr == 4'd8) ? wd[3:0] : 4'd0;
        m_st = (m_st & ~clr) | set;
        #1;
        event_i = '0; wr_en_i = 1'b0;
    endtask

    task automatic wr(logic [3:0] addr, logic [63:0] wd);
        cycle(8'd0, 2'd0, 1'b0, 4'd0, 1'b1, addr, wd);
    endtask

    task automatic check_reg(int a, string tag);
        reg_addr_i = 4'(a);
        #0.5;
        n_checks++;
        if (rd_data_o !== exp_reg(a)) begin
            n_fails++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data_o, exp_reg(a));
        end
    endtask

    task automatic check_all(string tag);
        for (int a = 0; a < 9; a++) check_reg(a, tag);
        n_checks++;
        if (irq_o !== exp_irq()) begin
            n_fails++;
            $display("FAIL %s irq actual %b expected %b", tag, irq_o, exp_irq());
        end
    endtask

    function automatic logic [63:0] mkcfg(logic ie, logic [1:0] mf, logic [3:0] mm, int sel);
        return {ie, mf, mm, 25'd0, 32'(sel)};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20200720;
        void'($urandom(seed));
        for (int k = 0; k < 4; k++) begin m_cnt[k] = '0; m_cfg[k] = '0; end
        m_st = '0;
        repeat (3) @(posedge clk_i);
        #1;
        check_all("R10 reset");
        rst_ni = 1'b1;

        // R1 R2: plain counting on event 3, selector out of range on counter 1
        wr(4'd4, mkcfg(1'b0, 2'b00, 4'b0000, 3));
        wr(4'd5, mkcfg(1'b0, 2'b00, 4'b0000, 9));
        repeat (5) cycle(8'hFF, 2'd3, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0);
        check_all("R1 R2 count");

        // R3: mask machine mode only on counter 0
        wr(4'd4, mkcfg(1'b0, 2'b00, 4'b1000, 3));
        cycle(8'h04, 2'd3, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0);
        cycle(8'h04, 2'd1, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0);
        check_all("R3 mode mask");

        // R5: inhibit stops counter 0
        cycle(8'h04, 2'd1, 1'b0, 4'b0001, 1'b0, 4'd0, 64'd0);
        check_all("R5 inhibit");

        // R11 R4: three counters on event 1 with any / marked / unmarked
        wr(4'd4, mkcfg(1'b0, 2'b00, 4'b0000, 1));
        wr(4'd5, mkcfg(1'b0, 2'b01, 4'b0000, 1));
        wr(4'd6, mkcfg(1'b0, 2'b10, 4'b0000, 1));
        wr(4'd7, mkcfg(1'b0, 2'b11, 4'b0000, 1));
        for (int i = 0; i < 4; i++) wr(4'(i), 64'd0);
        for (int i = 0; i < 7; i++) cycle(8'h01, 2'd0, (i % 3) == 0, 4'd0, 1'b0, 4'd0, 64'd0);
        check_all("R11 R4 marked filters");

        // R6 R8: top-bit rise on counter 0, interrupt enabled
        wr(4'd4, mkcfg(1'b1, 2'b00, 4'b0000, 1));
        wr(4'd0, 64'h7FFF_FFFF_FFFF_FFFE);
        cycle(8'h01, 2'd0, 1'b0, 4'b1110, 1'b0, 4'd0, 64'd0);
        check_all("R6 before boundary");
        cycle(8'h01, 2'd0, 1'b0, 4'b1110, 1'b0, 4'd0, 64'd0);
        check_all("R6 R8 overflow");

        // R6: wraparound of counter 1 sets nothing
        wr(4'd5, mkcfg(1'b1, 2'b00, 4'b0000, 2));
        wr(4'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        cycle(8'h02, 2'd0, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0);
        check_all("R6 wrap");

        // R7: clear wins nothing against a same-cycle overflow; plain clear works
        wr(4'd6, mkcfg(1'b0, 2'b00, 4'b0000, 3));
        wr(4'd2, 64'h7FFF_FFFF_FFFF_FFFF);
        cycle(8'h04, 2'd0, 1'b0, 4'd0, 1'b1, 4'd8, 64'h4);
        check_all("R7 set beats clear");
        wr(4'd8, 64'h1);
        check_all("R7 R8 clear");

        // R9: write beats increment; writing top bit sets no status
        wr(4'd8, 64'hF);
        cycle(8'h01, 2'd0, 1'b0, 4'd0, 1'b1, 4'd0, 64'h8000_0000_0000_0000);
        check_all("R9 write priority");
        wr(4'd3, 64'h8000_0000_0000_0000);
        check_all("R9 no status on write");

        // R10: unmapped address reads zero
        check_reg(12, "R10 unmapped");

        // random phase
        for (int i = 0; i < 1500; i++) begin
            logic we;
            logic [3:0] addr;
            logic [63:0] wd;
            we = ($urandom % 20) == 0;
            addr = 4'($urandom % 9);
            wd = {$urandom, $urandom};
            if (we && addr >= 4 && addr < 8)
                wd = mkcfg(1'($urandom), 2'($urandom), 4'($urandom), int'($urandom % 10));
            if (we && addr < 4 && ($urandom % 2) == 0)
                wd = 64'h7FFF_FFFF_FFFF_FFF0 + 64'($urandom % 16);
            cycle(8'($urandom), 2'($urandom), 1'($urandom), 4'($urandom % 16 == 0 ? 15 : 0),
                  we, addr, wd);
            check_all("R1 R2 R3 R4 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule